// File: doc/BRIEF.md
# Three-Channel Match/Reload Counter with Capture-on-Request Readout

This block holds three 32-bit up-counters behind a small synchronous register port. Each counter has three compare values of its own, a reload value, and a 2-bit reload selector. The selector picks which one of the three compare values sends the counter back to its reload value. A single enable register starts and stops each counter. Every compare value drives its own one-cycle match pulse output.

Software never reads a live count. It writes 1 to a counter's capture address. After a short synchroniser delay the block latches that counter's value, and a later read of the same address returns the latched value. The latched value stays put until the next capture request completes. A clock-control word is kept for software and can be read back, but it changes nothing in how the counters run. If compare 0 is set to all ones, the reload value to zero and compare 0 is selected, the counter runs free as a plain 32-bit counter.

Top module: `mpt_timer`

## Requirements
- R1: After reset, every count, captured value, reload value, compare value, reload selector and the clock-control word read as zero. All counters are disabled and no match pulse is high.
- R2: The enable register is at address 0x00, and bit t enables counter t. An enabled counter steps by one on each clock. A disabled counter holds its value, and the other counters do not affect it.
- R3: `matchPulse[3*t+m]` is high in exactly the cycles where counter t is enabled and its count equals compare value m. Compare value m of counter t is at address 0x0B+3*t+m.
- R4: The reload selector of counter t is at address 0x08+t and the reload value at 0x05+t. Selector value 0 means no reload. Selector value k (1 to 3) selects compare k-1, and the step that leaves a count equal to that compare value loads the reload value instead of incrementing.
- R5: When compare 0 is 0xFFFFFFFF, the reload value is 0 and the selector is 1, the counter moves from 0xFFFFFFFF to 0 and keeps counting up from there.
- R6: Writing exactly 0x1 to address 0x02+t latches counter t's count within 4 cycles, and reading that address returns the latched value. A write of any other value there is ignored. The latched value does not change except when a request completes.
- R7: The clock-control word at address 0x01 stores any value written and reads it back, and it has no effect on counting.
- R8: The reload values, compare values, selectors (2 bits) and enable bits (3 bits) read back what was written. The read result appears on `rdData` the cycle after `rdEn`. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 5 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| matchPulse | output | 9 | One match pulse per compare value, index 3*t+m |

## Verification
Assertions check four things on every cycle. A disabled counter holds. A counter with no reload selected steps by one. A match on the selected compare value is followed by the reload value. A latched value moves only when a synchroniser pulse arrives. Other behaviour can only be shown by the bench's scenarios. These are the exact counts reached under each timer/selector pairing, the wrap at all ones, the match pulse pattern cycle by cycle, capture requests with values other than 1 being ignored, register readback, and the clock-control word having no effect.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
  localparam int TMR_N  = 3;
  localparam int CMP_N  = 3;
  localparam int SLOT_N = TMR_N * CMP_N;
  localparam int IDX_W  = $clog2(SLOT_N);
  localparam int SEL_W  = $clog2(CMP_N + 1);

  typedef enum logic [2:0] {
    RD_NONE, RD_ENABLE, RD_CLKCTL, RD_SNAP, RD_PRELOAD, RD_PRECTL, RD_MATCH
  } rdKind_e;

  typedef struct packed {
    logic              wrEnable;
    logic              wrClkCtl;
    logic [TMR_N-1:0]  snapReq;
    logic [TMR_N-1:0]  wrPreload;
    logic [TMR_N-1:0]  wrPreCtl;
    logic [SLOT_N-1:0] wrMatch;
    logic              rdStrobe;
    rdKind_e           rdKind;
    logic [IDX_W-1:0]  rdIdx;
  } strobes_t;
endpackage

// File: rtl/mpt_ctrl.sv
module mpt_ctrl
  import mpt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output strobes_t          stb
);
  localparam int EN_A    = 0;
  localparam int CLK_A   = 1;
  localparam int SNAP_A  = 2;
  localparam int PRE_A   = SNAP_A + TMR_N;
  localparam int PCTL_A  = PRE_A + TMR_N;
  localparam int MATCH_A = PCTL_A + TMR_N;

  always_comb begin
    stb = '0;
    stb.rdKind   = RD_NONE;
    stb.rdStrobe = rdEn;
    stb.wrEnable = wrEn && (addr == ADDR_W'(EN_A));
    stb.wrClkCtl = wrEn && (addr == ADDR_W'(CLK_A));
    if (addr == ADDR_W'(EN_A))  stb.rdKind = RD_ENABLE;
    if (addr == ADDR_W'(CLK_A)) stb.rdKind = RD_CLKCTL;
    for (int t = 0; t < TMR_N; t++) begin
      stb.snapReq[t]   = wrEn && (addr == ADDR_W'(SNAP_A + t)) && (wrData == DATA_W'(1));
      stb.wrPreload[t] = wrEn && (addr == ADDR_W'(PRE_A + t));
      stb.wrPreCtl[t]  = wrEn && (addr == ADDR_W'(PCTL_A + t));
      if (addr == ADDR_W'(SNAP_A + t)) begin stb.rdKind = RD_SNAP;    stb.rdIdx = IDX_W'(t); end
      if (addr == ADDR_W'(PRE_A + t))  begin stb.rdKind = RD_PRELOAD; stb.rdIdx = IDX_W'(t); end
      if (addr == ADDR_W'(PCTL_A + t)) begin stb.rdKind = RD_PRECTL;  stb.rdIdx = IDX_W'(t); end
    end
    for (int i = 0; i < SLOT_N; i++) begin
      stb.wrMatch[i] = wrEn && (addr == ADDR_W'(MATCH_A + i));
      if (addr == ADDR_W'(MATCH_A + i)) begin stb.rdKind = RD_MATCH; stb.rdIdx = IDX_W'(i); end
    end
  end
endmodule

// File: rtl/mpt_datapath.sv
module mpt_datapath
  import mpt_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [SLOT_N-1:0] matchPulse
);
  logic [TMR_N-1:0]       enReg;
  logic [DATA_W-1:0]      clkCtl;
  logic [DATA_W-1:0]      count    [TMR_N];
  logic [DATA_W-1:0]      preload  [TMR_N];
  logic [SEL_W-1:0]       preCtl   [TMR_N];
  logic [DATA_W-1:0]      snapVal  [TMR_N];
  logic [SYNC_STAGES-1:0] snapSync [TMR_N];
  logic [DATA_W-1:0]      matchVal [SLOT_N];
  logic [TMR_N-1:0]       reloadHit;
  logic [DATA_W-1:0]      rdMux;

  always_ff @(posedge clk) begin
    if (rst) begin
      enReg  <= '0;
      clkCtl <= '0;
    end else begin
      if (stb.wrEnable) enReg  <= wrData[TMR_N-1:0];
      if (stb.wrClkCtl) clkCtl <= wrData;
    end
  end

  for (genvar i = 0; i < SLOT_N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) matchVal[i] <= '0;
      else if (stb.wrMatch[i]) matchVal[i] <= wrData;
    end
    assign matchPulse[i] = enReg[i / CMP_N] && (count[i / CMP_N] == matchVal[i]);
  end

  for (genvar t = 0; t < TMR_N; t++) begin : g_tmr
    always_comb begin
      reloadHit[t] = 1'b0;
      for (int m = 0; m < CMP_N; m++)
        if (preCtl[t] == SEL_W'(m + 1) && count[t] == matchVal[t * CMP_N + m])
          reloadHit[t] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        count[t]    <= '0;
        preload[t]  <= '0;
        preCtl[t]   <= '0;
        snapVal[t]  <= '0;
        snapSync[t] <= '0;
      end else begin
        if (stb.wrPreload[t]) preload[t] <= wrData;
        if (stb.wrPreCtl[t])  preCtl[t]  <= wrData[SEL_W-1:0];
        if (enReg[t]) count[t] <= reloadHit[t] ? preload[t] : count[t] + DATA_W'(1);
        snapSync[t] <= {snapSync[t][SYNC_STAGES-2:0], stb.snapReq[t]};
        if (snapSync[t][SYNC_STAGES-1]) snapVal[t] <= count[t];
      end
    end

    // R2: a stopped counter keeps its value
    p_hold_disabled_r2: assert property (@(posedge clk) disable iff (rst)
      !enReg[t] |=> $stable(count[t]));
    // R2: no reload selected means a plain increment
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
      enReg[t] && preCtl[t] == '0 |=> count[t] == $past(count[t]) + DATA_W'(1));
    // R6: latched value moves only on a completed request
    p_snap_stable_r6: assert property (@(posedge clk) disable iff (rst)
      !snapSync[t][SYNC_STAGES-1] |=> $stable(snapVal[t]));

    for (genvar m = 0; m < CMP_N; m++) begin : g_cmp
      // R4: a pulse on the selected compare is followed by the reload value
      p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        enReg[t] && preCtl[t] == SEL_W'(m + 1) && matchPulse[t * CMP_N + m]
        |=> count[t] == $past(preload[t]));
    end
  end

  always_comb begin
    rdMux = '0;
    case (stb.rdKind)
      RD_ENABLE: rdMux = {{(DATA_W-TMR_N){1'b0}}, enReg};
      RD_CLKCTL: rdMux = clkCtl;
      RD_SNAP:    for (int t = 0; t < TMR_N; t++) if (stb.rdIdx == IDX_W'(t)) rdMux = snapVal[t];
      RD_PRELOAD: for (int t = 0; t < TMR_N; t++) if (stb.rdIdx == IDX_W'(t)) rdMux = preload[t];
      RD_PRECTL:  for (int t = 0; t < TMR_N; t++)
                    if (stb.rdIdx == IDX_W'(t)) rdMux = {{(DATA_W-SEL_W){1'b0}}, preCtl[t]};
      RD_MATCH:   for (int i = 0; i < SLOT_N; i++) if (stb.rdIdx == IDX_W'(i)) rdMux = matchVal[i];
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else if (stb.rdStrobe) rdData <= rdMux;
  end
endmodule

// File: rtl/mpt_timer.sv
module mpt_timer
  import mpt_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [SLOT_N-1:0] matchPulse
);
  strobes_t stb;

  mpt_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData), .stb(stb)
  );

  mpt_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rst(rst), .stb(stb), .wrData(wrData),
    .rdData(rdData), .matchPulse(matchPulse)
  );
endmodule

// File: tb/test_mpt_timer.sv
module test_mpt_timer;
  localparam int A_EN = 0, A_CLK = 1, A_SNAP = 2, A_PRE = 5, A_PCTL = 8, A_MATCH = 11;

  logic        clk = 0, rst = 1, wrEn = 0, rdEn = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [8:0]  matchPulse;

  int nRun = 0, nFail = 0;
  logic [31:0] mCount [3];
  logic [31:0] mPre   [3];
  logic [1:0]  mCtl   [3];
  logic [31:0] mMatch [9];
  logic [31:0] rdVal;

  mpt_timer i_mpt_timer (.clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .matchPulse(matchPulse));

  always #2ns clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1; repeat (3) @(negedge clk); rst = 0;
    for (int t = 0; t < 3; t++) begin mCount[t] = 0; mPre[t] = 0; mCtl[t] = 0; end
    for (int i = 0; i < 9; i++) mMatch[i] = 0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr = 5'(a); wrData = d; wrEn = 1;
    @(posedge clk); @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input int a);
    addr = 5'(a); rdEn = 1;
    @(posedge clk); @(negedge clk); rdEn = 0; rdVal = rdData;
  endtask

  task automatic setMatch(input int i, input logic [31:0] v); wr(A_MATCH + i, v); mMatch[i] = v; endtask
  task automatic setPre(input int t, input logic [31:0] v);   wr(A_PRE + t, v);   mPre[t] = v;   endtask
  task automatic setCtl(input int t, input logic [1:0] v);    wr(A_PCTL + t, 32'(v)); mCtl[t] = v; endtask

  task automatic stepModel(input logic [2:0] mask);
    for (int t = 0; t < 3; t++)
      if (mask[t]) begin
        if (mCtl[t] != 0 && mCount[t] == mMatch[3 * t + int'(mCtl[t]) - 1]) mCount[t] = mPre[t];
        else mCount[t] = mCount[t] + 1;
      end
  endtask

  task automatic checkPulses(input logic [2:0] mask);
    logic [8:0] e;
    for (int i = 0; i < 9; i++) e[i] = mask[i / 3] && (mCount[i / 3] == mMatch[i]);
    chk(matchPulse == e, "R3 match pulses", 32'(matchPulse), 32'(e));
  endtask

  // enable mask, let K+1 steps happen, then stop
  task automatic run(input logic [2:0] mask, input int k);
    wr(A_EN, 32'(mask));
    for (int i = 0; i <= k; i++) begin
      checkPulses(mask);
      if (i < k) begin @(posedge clk); @(negedge clk); stepModel(mask); end
    end
    wr(A_EN, 0); stepModel(mask);
    checkPulses(3'b000);
  endtask

  task automatic readSnap(input int t);
    wr(A_SNAP + t, 1); repeat (3) @(negedge clk); rd(A_SNAP + t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    doReset();
    // R1 reset state
    foreach (mCount[t]) begin
      rd(A_SNAP + t); chk(rdVal == 0, "R1 capture", rdVal, 0);
      rd(A_PRE + t);  chk(rdVal == 0, "R1 reload", rdVal, 0);
      rd(A_PCTL + t); chk(rdVal == 0, "R1 selector", rdVal, 0);
    end
    rd(A_EN);  chk(rdVal == 0, "R1 enable", rdVal, 0);
    rd(A_CLK); chk(rdVal == 0, "R1 clkctl", rdVal, 0);
    for (int i = 0; i < 9; i++) begin rd(A_MATCH + i); chk(rdVal == 0, "R1 compare", rdVal, 0); end
    chk(matchPulse == 0, "R1 pulses", 32'(matchPulse), 0);
    readSnap(0); chk(rdVal == 0, "R1 count", rdVal, 0);

    // R8 readback
    for (int i = 0; i < 9; i++) setMatch(i, 32'h1357_0000 + 32'(i * 77));
    for (int i = 0; i < 9; i++) begin
      rd(A_MATCH + i); chk(rdVal == 32'h1357_0000 + 32'(i * 77), "R8 compare", rdVal, 32'h1357_0000 + 32'(i * 77));
    end
    for (int t = 0; t < 3; t++) begin
      setPre(t, 32'hA5A5_0000 | 32'(t)); setCtl(t, 2'(t + 1));
      rd(A_PRE + t);  chk(rdVal == (32'hA5A5_0000 | 32'(t)), "R8 reload", rdVal, 32'hA5A5_0000 | 32'(t));
      rd(A_PCTL + t); chk(rdVal == 32'(t + 1), "R8 selector", rdVal, 32'(t + 1));
    end
    wr(A_EN, 32'h5); rd(A_EN); chk(rdVal == 32'h5, "R8 enable", rdVal, 32'h5);
    wr(A_EN, 0);
    rd(20); chk(rdVal == 0, "R8 unmapped", rdVal, 0);

    // R4 / R3 sweep over every timer and selector
    for (int t = 0; t < 3; t++)
      for (int s = 0; s < 4; s++) begin
        doReset();
        for (int m = 0; m < 3; m++) setMatch(3 * t + m, 32'(3 + 2 * m + t));
        setPre(t, 32'(40 + s)); setCtl(t, 2'(s));
        run(3'(1 << t), 14);
        readSnap(t); chk(rdVal == mCount[t], "R4 reload sweep", rdVal, mCount[t]);
        readSnap((t + 1) % 3); chk(rdVal == 0, "R2 idle neighbour", rdVal, 0);
      end

    // R2 independent enables
    doReset();
    run(3'b011, 9);
    run(3'b100, 4);
    for (int t = 0; t < 3; t++) begin
      readSnap(t); chk(rdVal == mCount[t], "R2 per-timer enable", rdVal, mCount[t]);
    end
    chk(mCount[0] == 10 && mCount[2] == 5, "R2 model sanity", mCount[2], 5);

    // R5 free-running wrap
    doReset();
    setMatch(4, 2); setPre(1, 32'hFFFF_FFFA); setCtl(1, 2);
    run(3'b010, 2);
    readSnap(1); chk(rdVal == 32'hFFFF_FFFA, "R5 near top", rdVal, 32'hFFFF_FFFA);
    setPre(1, 0); setMatch(3, 32'hFFFF_FFFF); setCtl(1, 1);
    run(3'b010, 9);
    readSnap(1); chk(rdVal == 32'd4, "R5 wrap", rdVal, 32'd4);

    // R6 capture semantics
    doReset();
    run(3'b001, 6);
    readSnap(0); chk(rdVal == 7, "R6 capture", rdVal, 7);
    run(3'b001, 3);
    wr(A_SNAP, 2); repeat (4) @(negedge clk); rd(A_SNAP);
    chk(rdVal == 7, "R6 other value ignored", rdVal, 7);
    readSnap(0); chk(rdVal == 11, "R6 new capture", rdVal, 11);
    wr(A_EN, 1); wr(A_SNAP, 1); repeat (4) @(negedge clk);
    rd(A_SNAP); a = rdVal; repeat (6) @(negedge clk);
    rd(A_SNAP); b = rdVal; wr(A_EN, 0);
    chk(a == b, "R6 stable while running", b, a);
    chk(a >= 11 && a <= 16, "R6 capture latency", a, 11);

    // R7 clock-control word
    doReset();
    wr(A_CLK, 32'hDEAD_BEEF);
    rd(A_CLK); chk(rdVal == 32'hDEAD_BEEF, "R7 clkctl store", rdVal, 32'hDEAD_BEEF);
    run(3'b001, 5);
    readSnap(0); chk(rdVal == 6, "R7 no effect on counting", rdVal, 6);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule